// File: doc/BRIEF.md
# Parameter List Scanner

This block walks the chain of parameter blocks that can follow a version-1 feature header and looks for one parameter by its ID. A start pulse supplies the byte address of the header and the wanted ID. The scanner then fetches 64-bit words through a single-outstanding read port. It first reads the capability word, which says whether any parameter list exists. If one does, it follows the chain of parameter headers from the first one until it finds a match, reaches the final block, or meets a broken link.

When the scan ends, the block raises a one-cycle completion pulse. Alongside it, it presents these results:
- a found flag and an error flag;
- the matched parameter's version;
- the first data word of the matched parameter;
- the block-size field of the matched parameter;
- the register-set size, group and instance fields taken from the capability word.

Firmware-assist logic or a discovery engine uses the block to pull a single capability value out of a feature without walking the list in software.

Top module: `param_list_scanner`

## Requirements
- R1: After reset, busy_o, done_o and rd_req_o are all low.
- R2: A start_i pulse while idle issues the first read at base_addr_i + 0x20 (the capability word) on the next cycle. base_addr_i is 8-byte aligned, and every read address stays 8-byte aligned. A start_i while busy_o is high is ignored and gives no extra completion.
- R3: If bit 31 of the capability word is 0, the scan completes with found_o=0 and err_o=0 after that single read. In that case param_ver_o, param_data_o and param_size_o read 0.
- R4: If bit 31 is 1, the first parameter header is read at base + 0x28.
- R5: A parameter header holds the ID in bits 15:0, the version in 31:16, the last-block flag at bit 32 and the next field in 63:35. For a block that is not last, the next header is at the current header address plus next×8 bytes.
- R6: When the header ID equals target_id_i, the word at header address + 8 is read. The scan then completes with found_o=1, param_ver_o set to the version, param_data_o set to that word and param_size_o set to the next field.
- R7: A non-matching header with the last-block flag set ends the scan with found_o=0 and err_o=0, and no further read is made.
- R8: A non-matching header that is not last and has a zero next field ends the scan with err_o=1 and found_o=0, and no further read is made.
- R9: When several blocks carry the requested ID, the first one in chain order is returned.
- R10: reg_size_o, group_o and inst_o report bits 63:32, 30:16 and 15:0 of the capability word, whether or not a match is found.
- R11: done_o is a one-cycle pulse, busy_o falls on the cycle after it, and found_o and err_o are never both high.
- R12: A match on the last block returns its next field, which is there the size of that parameter in 8-byte words, as param_size_o.
- R13: At most one read is outstanding: after rd_req_o, no new request is made until rd_valid_i returns the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a scan (accepted only while idle) |
| base_addr_i | input | AW | Byte address of the feature header, 8-byte aligned |
| target_id_i | input | 16 | Parameter ID to look for |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | Requested parameter located |
| err_o | output | 1 | Broken chain (zero link on a non-final block) |
| param_ver_o | output | 16 | Version of the matched parameter |
| param_data_o | output | 64 | First data word of the matched parameter |
| param_size_o | output | 29 | Next/size field of the matched parameter, in 8-byte words |
| reg_size_o | output | 32 | Register-set size from the capability word |
| group_o | output | 15 | Group ID from the capability word |
| inst_o | output | 16 | Instance ID from the capability word |
| rd_req_o | output | 1 | Read request, one cycle |
| rd_addr_o | output | AW | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Read data |

## Verification
The assertions check the following on every cycle:
- the first read goes to the capability word;
- only one read is outstanding at a time;
- read addresses stay aligned;
- the completion pulse lasts one cycle and busy_o falls after it;
- found and error are never reported together.

Only the bench scenarios can show the following:
- that the chain is followed with word-scaled offsets;
- that the first of several duplicate IDs wins;
- that a last-block match reports the size value;
- that a missing list or a zero link stops the walk after the right number of reads.

The bench observes these through the returned fields and the read count seen by its memory model, with the read latency varied between scans.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  localparam int unsigned CAP_OFS   = 32'h20;
  localparam int unsigned PLIST_OFS = 32'h28;
  localparam int unsigned ID_W      = 16;
  localparam int unsigned LINK_W    = 29;

  typedef struct packed {
    logic [LINK_W-1:0] nxt;
    logic [1:0]        rsv;
    logic              last;
    logic [15:0]       ver;
    logic [ID_W-1:0]   id;
  } phdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_CAP, S_WAIT_CAP, S_REQ_HDR,
    S_WAIT_HDR, S_REQ_DAT, S_WAIT_DAT, S_DONE
  } st_e;
endpackage

// File: rtl/pscan_hdr_decode.sv
module pscan_hdr_decode
  import pscan_pkg::*;
(
  input  logic [63:0]     word_i,
  input  logic [ID_W-1:0] target_i,
  output phdr_t           hdr_o,
  output logic            hit_o,
  output logic            last_o,
  output logic            dead_o
);
  assign hdr_o  = phdr_t'(word_i);
  assign hit_o  = (hdr_o.id == target_i);
  assign last_o = hdr_o.last;
  // zero link on a non-final block would re-read the same header forever
  assign dead_o = !hdr_o.last && (hdr_o.nxt == '0);
endmodule

// File: rtl/pscan_addr_gen.sv
module pscan_addr_gen
  import pscan_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     load_val_i,
  input  logic              adv_i,
  input  logic [LINK_W-1:0] adv_words_i,
  output logic [AW-1:0]     addr_o
);
  localparam int unsigned STEP_W = LINK_W + 3;

  logic [AW-1:0]     addr_q;
  logic [STEP_W-1:0] step_bytes;

  assign step_bytes = {adv_words_i, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_val_i;
    else if (adv_i)  addr_q <= addr_q + AW'(step_bytes);
  end

  assign addr_o = addr_q;

  // R2: word steps keep the read pointer aligned
  a_r2_step_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (addr_o[2:0] == $past(addr_o[2:0])));
endmodule

// File: rtl/param_list_scanner.sv
module param_list_scanner
  import pscan_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [ID_W-1:0]   target_id_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              found_o,
  output logic              err_o,
  output logic [15:0]       param_ver_o,
  output logic [63:0]       param_data_o,
  output logic [LINK_W-1:0] param_size_o,
  output logic [31:0]       reg_size_o,
  output logic [14:0]       group_o,
  output logic [15:0]       inst_o,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [63:0]       rd_data_i
);
  localparam logic [AW-1:0] CAP_A   = AW'(CAP_OFS);
  localparam logic [AW-1:0] PLIST_A = AW'(PLIST_OFS);

  st_e               st_q, st_d;
  logic [AW-1:0]     base_q;
  logic [ID_W-1:0]   tgt_q;
  phdr_t             hdr;
  logic              hit, last, dead;
  logic              ld, adv;
  logic [AW-1:0]     ld_val;
  logic [LINK_W-1:0] adv_words;

  logic              found_q, err_q;
  logic [15:0]       ver_q;
  logic [63:0]       data_q;
  logic [LINK_W-1:0] size_q;
  logic [31:0]       regsz_q;
  logic [14:0]       grp_q;
  logic [15:0]       inst_q;

  logic start_ok;
  assign start_ok = (st_q == S_IDLE) && start_i;

  pscan_hdr_decode u_dec (
    .word_i  (rd_data_i),
    .target_i(tgt_q),
    .hdr_o   (hdr),
    .hit_o   (hit),
    .last_o  (last),
    .dead_o  (dead)
  );

  pscan_addr_gen #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (ld_val),
    .adv_i      (adv),
    .adv_words_i(adv_words),
    .addr_o     (rd_addr_o)
  );

  always_comb begin
    st_d      = st_q;
    ld        = 1'b0;
    ld_val    = base_q + PLIST_A;
    adv       = 1'b0;
    adv_words = hdr.nxt;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d   = S_REQ_CAP;
        ld     = 1'b1;
        ld_val = base_addr_i + CAP_A;
      end
      S_REQ_CAP:  st_d = S_WAIT_CAP;
      S_WAIT_CAP: if (rd_valid_i) begin
        if (rd_data_i[31]) begin
          st_d = S_REQ_HDR;
          ld   = 1'b1;
        end else begin
          st_d = S_DONE;
        end
      end
      S_REQ_HDR:  st_d = S_WAIT_HDR;
      S_WAIT_HDR: if (rd_valid_i) begin
        if (hit) begin
          adv       = 1'b1;
          adv_words = LINK_W'(1);
          st_d      = S_REQ_DAT;
        end else if (last || dead) begin
          st_d = S_DONE;
        end else begin
          adv  = 1'b1;
          st_d = S_REQ_HDR;
        end
      end
      S_REQ_DAT:  st_d = S_WAIT_DAT;
      S_WAIT_DAT: if (rd_valid_i) st_d = S_DONE;
      S_DONE:     st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      base_q  <= '0;
      tgt_q   <= '0;
      found_q <= 1'b0;
      err_q   <= 1'b0;
      ver_q   <= '0;
      data_q  <= '0;
      size_q  <= '0;
      regsz_q <= '0;
      grp_q   <= '0;
      inst_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start_ok) begin
        base_q  <= base_addr_i;
        tgt_q   <= target_id_i;
        found_q <= 1'b0;
        err_q   <= 1'b0;
        ver_q   <= '0;
        data_q  <= '0;
        size_q  <= '0;
      end
      if (st_q == S_WAIT_CAP && rd_valid_i) begin
        regsz_q <= rd_data_i[63:32];
        grp_q   <= rd_data_i[30:16];
        inst_q  <= rd_data_i[15:0];
      end
      if (st_q == S_WAIT_HDR && rd_valid_i) begin
        if (hit) begin
          ver_q  <= hdr.ver;
          size_q <= hdr.nxt;
        end else if (dead) begin
          err_q <= 1'b1;
        end
      end
      if (st_q == S_WAIT_DAT && rd_valid_i) begin
        data_q  <= rd_data_i;
        found_q <= 1'b1;
      end
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_DONE);
  assign rd_req_o     = (st_q == S_REQ_CAP) || (st_q == S_REQ_HDR) || (st_q == S_REQ_DAT);
  assign found_o      = found_q;
  assign err_o        = err_q;
  assign param_ver_o  = ver_q;
  assign param_data_o = data_q;
  assign param_size_o = size_q;
  assign reg_size_o   = regsz_q;
  assign group_o      = grp_q;
  assign inst_o       = inst_q;

  a_r2_cap_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (rd_req_o && rd_addr_o == $past(base_addr_i) + CAP_A));

  a_r13_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> !rd_req_o);

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r11_found_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(found_o && err_o));

  a_r3_no_read_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);
endmodule

// File: tb/tb_param_list_scanner.sv
`timescale 1ns/1ps
module tb_param_list_scanner;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [15:0] tgt = '0;
  logic busy, done, found, err, rd_req, rd_valid;
  logic [15:0] ver, inst;
  logic [63:0] pdata, rd_data;
  logic [28:0] psize;
  logic [31:0] regsz;
  logic [14:0] grp;
  logic [AW-1:0] rd_addr;

  always #5 clk = ~clk;

  param_list_scanner #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .target_id_i(tgt), .busy_o(busy), .done_o(done), .found_o(found),
    .err_o(err), .param_ver_o(ver), .param_data_o(pdata), .param_size_o(psize),
    .reg_size_o(regsz), .group_o(grp), .inst_o(inst), .rd_req_o(rd_req),
    .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data)
  );

  int errors = 0, checks = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, 8-byte words
  logic [63:0] mem [256];
  int lat = 0;
  int nreads = 0;
  logic pend = 1'b0;
  logic [AW-1:0] paddr = '0;
  int cnt = 0;

  initial rd_valid = 1'b0;
  initial rd_data = '0;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      pend   <= 1'b1;
      paddr  <= rd_addr;
      cnt    <= lat;
      nreads <= nreads + 1;
    end else if (pend) begin
      if (cnt == 0) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[paddr[10:3]];
        pend     <= 1'b0;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  function automatic logic [63:0] phw(input logic [15:0] id, input logic [15:0] v,
                                      input bit last, input logic [28:0] nxt);
    return {nxt, 2'b00, last, v, id};
  endfunction

  function automatic logic [63:0] capw(input logic [31:0] sz, input bit flag,
                                       input logic [14:0] g, input logic [15:0] i);
    return {sz, flag, g, i};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    mem[a[10:3]] = d;
  endtask

  typedef struct {
    string       req;
    bit          found;
    bit          err;
    logic [15:0] ver;
    logic [63:0] data;
    logic [28:0] size;
    logic [31:0] regsz;
    logic [14:0] grp;
    logic [15:0] inst;
    int          reads0;
    int          nrd;
  } exp_t;

  exp_t sb[$];

  // monitor: compares each completion against the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(found == e.found, {e.req, " found"}, 64'(found), 64'(e.found));
          check(err == e.err, {e.req, " err"}, 64'(err), 64'(e.err));
          check(ver == e.ver, {e.req, " ver"}, 64'(ver), 64'(e.ver));
          check(pdata == e.data, {e.req, " data"}, pdata, e.data);
          check(psize == e.size, {e.req, " size"}, 64'(psize), 64'(e.size));
          check(regsz == e.regsz, {e.req, " R10 reg_size"}, 64'(regsz), 64'(e.regsz));
          check(grp == e.grp, {e.req, " R10 group"}, 64'(grp), 64'(e.grp));
          check(inst == e.inst, {e.req, " R10 inst"}, 64'(inst), 64'(e.inst));
          check(nreads - e.reads0 == e.nrd, {e.req, " read count"},
                64'(nreads - e.reads0), 64'(e.nrd));
        end
      end
    end
  end

  task automatic scan(input string req, input logic [AW-1:0] b, input logic [15:0] t,
                      input bit f, input bit er, input logic [15:0] v,
                      input logic [63:0] d, input logic [28:0] sz,
                      input logic [31:0] rs, input logic [14:0] g,
                      input logic [15:0] i, input int nrd, input bit poke);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    e.req = req; e.found = f; e.err = er; e.ver = v; e.data = d; e.size = sz;
    e.regsz = rs; e.grp = g; e.inst = i; e.reads0 = nreads; e.nrd = nrd;
    sb.push_back(e);
    base = b; tgt = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      base = 16'h0300; tgt = 16'h0008; start = 1'b1;  // R11: start while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = {48'hBAD0_BAD0_BAD0, 16'(k)};
    // list absent
    wr(16'h0020, capw(32'h1000, 1'b0, 15'h5, 16'h7));
    // chain at 0x100: 0x128 -> 0x148 -> 0x160(last)
    wr(16'h0120, capw(32'h0200, 1'b1, 15'h1, 16'h2));
    wr(16'h0128, phw(16'h11, 16'h3, 1'b0, 29'd4));
    wr(16'h0130, 64'hA5A5_0000_1111_2222);
    wr(16'h0148, phw(16'h22, 16'h1, 1'b0, 29'd3));
    wr(16'h0150, 64'h2222_2222_2222_2222);
    wr(16'h0160, phw(16'h33, 16'h9, 1'b1, 29'd2));
    wr(16'h0168, 64'h3333_4444_5555_6666);
    // zero link at 0x228
    wr(16'h0220, capw(32'h0040, 1'b1, 15'h7FFF, 16'hFFFF));
    wr(16'h0228, phw(16'h05, 16'h2, 1'b0, 29'd0));
    wr(16'h0230, 64'h0505_0505_0505_0505);
    // duplicates at 0x300
    wr(16'h0320, capw(32'h0080, 1'b1, 15'h3, 16'h4));
    wr(16'h0328, phw(16'h07, 16'h1, 1'b0, 29'd2));
    wr(16'h0338, phw(16'h08, 16'h4, 1'b0, 29'd2));
    wr(16'h0340, 64'h1111_0000_0000_1111);
    wr(16'h0348, phw(16'h08, 16'h5, 1'b1, 29'd1));
    wr(16'h0350, 64'h2222_0000_0000_2222);

    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    check(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    check(rd_req == 1'b0, "R1 rd_req after reset", 64'(rd_req), 64'd0);
    rst_n = 1'b1;

    lat = 0;
    scan("R3 no list", 16'h0000, 16'h11, 0, 0, 0, 0, 0, 32'h1000, 15'h5, 16'h7, 1, 0);
    scan("R4 R6 first block", 16'h0100, 16'h11, 1, 0, 16'h3, 64'hA5A5_0000_1111_2222,
         29'd4, 32'h0200, 15'h1, 16'h2, 3, 0);
    lat = 3;
    scan("R5 R12 last block", 16'h0100, 16'h33, 1, 0, 16'h9, 64'h3333_4444_5555_6666,
         29'd2, 32'h0200, 15'h1, 16'h2, 5, 0);
    scan("R7 absent id", 16'h0100, 16'h44, 0, 0, 0, 0, 0, 32'h0200, 15'h1, 16'h2, 4, 0);
    lat = 1;
    scan("R8 zero link", 16'h0200, 16'h09, 0, 1, 0, 0, 0, 32'h0040, 15'h7FFF, 16'hFFFF, 2, 0);
    scan("R6 match on zero link block", 16'h0200, 16'h05, 1, 0, 16'h2,
         64'h0505_0505_0505_0505, 29'd0, 32'h0040, 15'h7FFF, 16'hFFFF, 3, 0);
    lat = 2;
    scan("R9 first duplicate", 16'h0300, 16'h08, 1, 0, 16'h4, 64'h1111_0000_0000_1111,
         29'd2, 32'h0080, 15'h3, 16'h4, 4, 0);
    scan("R11 start while busy", 16'h0100, 16'h11, 1, 0, 16'h3, 64'hA5A5_0000_1111_2222,
         29'd4, 32'h0200, 15'h1, 16'h2, 3, 1);
    lat = 0;
    scan("R3 after error clears flags", 16'h0000, 16'h05, 0, 0, 0, 0, 0,
         32'h1000, 15'h5, 16'h7, 1, 0);

    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R11 pending expectations", 64'(sb.size()), 64'd0);
    check(busy == 1'b0, "R11 idle at end", 64'(busy), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule